// File: doc/BRIEF.md
# Power Rail Enable Sequencer

This block decides, for one output rail of a digital power controller, when switching may run. It combines three inputs: an input-undervoltage-lockout flag, an external enable pin whose active level is programmable, and an on bit written over the management bus. A four-bit configuration word selects which of these inputs must agree before the rail starts. When the selected condition becomes true, the sequencer waits a programmable turn-on delay. It then runs a programmable rise interval while the soft-start ramp is active, and then holds the rail on. When the condition goes false, it waits a programmable turn-off delay and then inhibits switching. Lockout overrides everything and drops the rail at once.

The three intervals are counted in ticks of a prescaled timebase. The prescaler restarts on every state change, so each interval is exact in clock cycles. The power-good output is qualified by the sequencer state. It can therefore drive the enable pin of a neighbouring rail, which lets several rails start and stop in a chain.

Top module: `rail_seq_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `seq_state_o` is 0 (off) and `sw_en_o`, `ramp_active_o` and `pgood_o` are low. State codes are: 0 off, 1 turn-on delay, 2 rise, 3 on, 4 turn-off delay.
- R2: When `gate_cfg_i[3]` is 0, the on-condition is simply "not in lockout". The levels of `ctl_pin_i` and `bus_on_i` are ignored.
- R3: When `gate_cfg_i[3]` and `gate_cfg_i[2]` are both 1, the on-condition also requires `bus_on_i` to be 1.
- R4: When `gate_cfg_i[3]` and `gate_cfg_i[1]` are both 1, the on-condition also requires `ctl_pin_i` to equal `gate_cfg_i[0]`. A value of 1 in that bit means active-high; 0 means active-low.
- R5: From off, a true on-condition enters the turn-on delay at the next edge. The delay lasts `ton_ticks_i*PRESCALE+1` cycles with `sw_en_o` low, and then the sequencer enters rise. A zero value gives a single cycle.
- R6: The rise state lasts `rise_ticks_i*PRESCALE+1` cycles and is followed by on. `ramp_active_o` is high only in rise. `sw_en_o` is high in rise, on and turn-off delay.
- R7: If the on-condition drops during the turn-on delay, the sequencer returns to off at the next edge, and switching is never enabled.
- R8: If the on-condition drops while on, the sequencer enters the turn-off delay. That delay lasts `toff_ticks_i*PRESCALE+1` cycles with `sw_en_o` high, and then the sequencer returns to off.
- R9: If the on-condition returns during the turn-off delay, the sequencer goes straight back to on at the next edge, without a new rise.
- R10: While `uvlo_i` is 1, `sw_en_o` and `pgood_o` are low in that same cycle. The state is off after the next edge, whatever state it was in.
- R11: `pgood_o` is high exactly when the state is on and `vout_ok_i` is 1. It stays low in every other state, even with `vout_ok_i` high.
- R12: A drop of the on-condition during rise is not acted on until the rise completes. The sequencer then spends one cycle in on and enters the turn-off delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uvlo_i | input | 1 | 1 while input supply is in undervoltage lockout |
| ctl_pin_i | input | 1 | External enable pin |
| bus_on_i | input | 1 | On bit written over the management bus |
| gate_cfg_i | input | 4 | [3] honour gates, [2] need bus bit, [1] need pin, [0] pin active level |
| ton_ticks_i | input | DLY_W | Turn-on delay in ticks |
| rise_ticks_i | input | DLY_W | Rise interval in ticks |
| toff_ticks_i | input | DLY_W | Turn-off delay in ticks |
| vout_ok_i | input | 1 | Output above its power-good threshold |
| sw_en_o | output | 1 | Switching enable |
| ramp_active_o | output | 1 | Soft-start ramp running |
| pgood_o | output | 1 | Power good |
| seq_state_o | output | 3 | Current sequencer state code |

## Verification
Two events can land in the same cycle. The first is a drop of the on-condition while the rise counter is still running: the rise must finish, and only the cycle in on that follows may react. The bench removes the bus bit on the first rise cycle and checks the state on every edge up to the turn-off delay. The second is lockout arriving while power-good and switching are high: both must fall in that same cycle, before the state register moves. The bench raises lockout mid-cycle and samples the outputs a nanosecond later.

// File: rtl/rail_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the rail sequencer: state codes and the gate
// configuration layout. The state codes are visible on a port.
package rail_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_OFF     = 3'd0,
        SEQ_ON_DLY  = 3'd1,
        SEQ_RAMP    = 3'd2,
        SEQ_ON      = 3'd3,
        SEQ_OFF_DLY = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic honor;     // 0: run whenever out of lockout
        logic need_cmd;  // require bus on bit
        logic need_pin;  // require control pin
        logic pin_pol;   // 1 = pin active high
    } gate_cfg_t;

endpackage

// File: rtl/rail_gate_decode.sv
`timescale 1ns/1ps
// Combines lockout, control pin and bus bit into one on-condition.
// The decode is purely combinational. Inputs are assumed already
// synchronised to clk.
module rail_gate_decode
    import rail_seq_pkg::*;
(
    input  gate_cfg_t cfg_i,
    input  logic      uvlo_i,
    input  logic      pin_i,
    input  logic      cmd_i,
    output logic      run_o
);

    logic pin_ok;
    logic cmd_ok;

    // Gate qualification per selected source
    always_comb begin
        pin_ok = !cfg_i.need_pin || (pin_i == cfg_i.pin_pol);
        cmd_ok = !cfg_i.need_cmd || cmd_i;
        run_o  = !uvlo_i && (!cfg_i.honor || (pin_ok && cmd_ok));
    end

endmodule

// File: rtl/rail_tick_gen.sv
`timescale 1ns/1ps
// Restartable prescaler. It issues one tick every PRESCALE cycles,
// counted from the last restart. The restart input realigns the
// phase so that every interval starts on a fresh tick period.
module rail_tick_gen #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);

    localparam int PRE_W = $clog2(PRESCALE + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] pre_q;

    assign tick_o = (pre_q == PRE_LAST);

    // Phase counter, cleared on restart or wrap
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || tick_o) pre_q <= '0;
        else                               pre_q <= pre_q + 1'b1;
    end

    generate
        if (PRESCALE > 1) begin : g_spacing
            // R5
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/rail_seq_fsm.sv
`timescale 1ns/1ps
// Five-state enable sequencer with a shared down-counter. The counter
// is loaded on each state change and decremented on every tick. A
// counter at zero ends the interval at the next edge. Lockout has
// priority in every state.
module rail_seq_fsm
    import rail_seq_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uvlo_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [DLY_W-1:0] ton_i,
    input  logic [DLY_W-1:0] rise_i,
    input  logic [DLY_W-1:0] toff_i,
    output seq_state_e       state_o,
    output logic             restart_o
);

    seq_state_e       state_q, state_d;
    logic [DLY_W-1:0] cnt_q, load_val;
    logic             cnt_zero;

    assign cnt_zero  = (cnt_q == '0);
    assign restart_o = (state_d != state_q);
    assign state_o   = state_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_OFF:     if (run_i) state_d = SEQ_ON_DLY;
            SEQ_ON_DLY:  if (!run_i) state_d = SEQ_OFF;
                         else if (cnt_zero) state_d = SEQ_RAMP;
            SEQ_RAMP:    if (uvlo_i) state_d = SEQ_OFF;
                         else if (cnt_zero) state_d = SEQ_ON;
            SEQ_ON:      if (uvlo_i) state_d = SEQ_OFF;
                         else if (!run_i) state_d = SEQ_OFF_DLY;
            SEQ_OFF_DLY: if (uvlo_i) state_d = SEQ_OFF;
                         else if (run_i) state_d = SEQ_ON;
                         else if (cnt_zero) state_d = SEQ_OFF;
            default:     state_d = SEQ_OFF;
        endcase
    end

    // Interval length for the state being entered
    always_comb begin
        unique case (state_d)
            SEQ_ON_DLY:  load_val = ton_i;
            SEQ_RAMP:    load_val = rise_i;
            SEQ_OFF_DLY: load_val = toff_i;
            default:     load_val = '0;
        endcase
    end

    // State register and interval counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (restart_o)              cnt_q <= load_val;
            else if (tick_i && !cnt_zero) cnt_q <= cnt_q - 1'b1;
        end
    end

    // R10
    uvlo_force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |=> state_q == SEQ_OFF);
    // R7
    ondly_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_ON_DLY && !run_i) |=> state_q == SEQ_OFF);
    // R9
    offdly_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_OFF_DLY && run_i && !uvlo_i) |=> state_q == SEQ_ON);
    // R12
    ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RAMP && !uvlo_i && !cnt_zero) |=> state_q == SEQ_RAMP);
    // R5
    off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SEQ_OFF |=> (state_q == SEQ_OFF || state_q == SEQ_ON_DLY));
    // R5
    cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SEQ_OFF && $stable(state_q)) |-> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/rail_seq_top.sv
`timescale 1ns/1ps
// Per-rail enable sequencer top. It wires the gate decode, the
// restartable prescaler and the state machine together, and derives
// the switching enable, ramp flag and power-good from the state.
// Lockout masks the enable and power-good combinationally.
module rail_seq_top
    import rail_seq_pkg::*;
#(
    parameter int DLY_W    = 16,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uvlo_i,
    input  logic             ctl_pin_i,
    input  logic             bus_on_i,
    input  logic [3:0]       gate_cfg_i,
    input  logic [DLY_W-1:0] ton_ticks_i,
    input  logic [DLY_W-1:0] rise_ticks_i,
    input  logic [DLY_W-1:0] toff_ticks_i,
    input  logic             vout_ok_i,
    output logic             sw_en_o,
    output logic             ramp_active_o,
    output logic             pgood_o,
    output logic [2:0]       seq_state_o
);

    logic       run;
    logic       tick;
    logic       restart;
    seq_state_e state;

    rail_gate_decode u_gate (
        .cfg_i  (gate_cfg_t'(gate_cfg_i)),
        .uvlo_i (uvlo_i),
        .pin_i  (ctl_pin_i),
        .cmd_i  (bus_on_i),
        .run_o  (run)
    );

    rail_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .tick_o    (tick)
    );

    rail_seq_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .uvlo_i    (uvlo_i),
        .run_i     (run),
        .tick_i    (tick),
        .ton_i     (ton_ticks_i),
        .rise_i    (rise_ticks_i),
        .toff_i    (toff_ticks_i),
        .state_o   (state),
        .restart_o (restart)
    );

    // Output decode from state, masked by lockout
    always_comb begin
        seq_state_o   = state;
        ramp_active_o = (state == SEQ_RAMP);
        sw_en_o       = !uvlo_i && (state == SEQ_RAMP || state == SEQ_ON ||
                                    state == SEQ_OFF_DLY);
        pgood_o       = !uvlo_i && (state == SEQ_ON) && vout_ok_i;
    end

    // R11
    pgood_needs_vout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgood_o |-> vout_ok_i);

endmodule

// File: tb/rail_seq_top_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module rail_seq_top_tb_top;

    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uvlo = 1'b1, pin = 1'b0, bon = 1'b0, vok = 1'b0;
    logic [3:0]  cfg = 4'd0;
    logic [15:0] ton = '0, rise = '0, toff = '0;
    logic        sw_en, ramp, pgood;
    logic [2:0]  st;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    rail_seq_top #(.DLY_W(16), .PRESCALE(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .ctl_pin_i(pin),
        .bus_on_i(bon), .gate_cfg_i(cfg), .ton_ticks_i(ton),
        .rise_ticks_i(rise), .toff_ticks_i(toff), .vout_ok_i(vok),
        .sw_en_o(sw_en), .ramp_active_o(ramp), .pgood_o(pgood),
        .seq_state_o(st)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic park();
        uvlo = 1'b1;
        cyc(2);
        chk("R10 park state", st, 0);
    endtask

    task automatic t_reset();
        cyc(3);
        chk("R1 reset state", st, 0);
        chk("R1 reset sw_en", sw_en, 0);
        chk("R1 reset ramp", ramp, 0);
        chk("R1 reset pgood", pgood, 0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 post-reset state", st, 0);
    endtask

    task automatic t_always_on();
        park();
        cfg = 4'b0000; pin = 1'b0; bon = 1'b0;
        ton = 16'd2; rise = 16'd3; vok = 1'b1;
        uvlo = 1'b0;
        cyc(1);
        chk("R2 starts ignoring pin and bus", st, 1);
        chk("R5 sw_en low in on-delay", sw_en, 0);
        cyc(8);
        chk("R5 on-delay last cycle", st, 1);
        cyc(1);
        chk("R5 enters rise", st, 2);
        chk("R6 ramp_active in rise", ramp, 1);
        chk("R6 sw_en in rise", sw_en, 1);
        chk("R11 pgood low in rise", pgood, 0);
        cyc(12);
        chk("R6 rise last cycle", st, 2);
        cyc(1);
        chk("R6 enters on", st, 3);
        chk("R6 ramp_active low in on", ramp, 0);
        chk("R11 pgood high in on", pgood, 1);
        vok = 1'b0;
        #1;
        chk("R11 pgood follows vout", pgood, 0);
        vok = 1'b1;
        cyc(1);
        uvlo = 1'b1;
        #1;
        chk("R10 sw_en drops same cycle", sw_en, 0);
        chk("R10 pgood drops same cycle", pgood, 0);
        cyc(1);
        chk("R10 state off after edge", st, 0);
    endtask

    task automatic t_cmd_gate();
        park();
        cfg = 4'b1100; bon = 1'b0; ton = 16'd0; rise = 16'd0; toff = 16'd1;
        uvlo = 1'b0;
        cyc(5);
        chk("R3 held off without bus bit", st, 0);
        bon = 1'b1;
        cyc(1);
        chk("R3 starts with bus bit", st, 1);
        cyc(1);
        chk("R5 zero on-delay one cycle", st, 2);
        cyc(1);
        chk("R6 zero rise one cycle", st, 3);
        bon = 1'b0;
        cyc(1);
        chk("R8 enters off-delay", st, 4);
        chk("R8 sw_en in off-delay", sw_en, 1);
        cyc(4);
        chk("R8 off-delay last cycle", st, 4);
        cyc(1);
        chk("R8 returns off", st, 0);
        chk("R8 sw_en low after off-delay", sw_en, 0);
    endtask

    task automatic t_pin_gate();
        park();
        cfg = 4'b1010; pin = 1'b1; ton = 16'd0; rise = 16'd0;
        uvlo = 1'b0;
        cyc(4);
        chk("R4 active-low pin high holds off", st, 0);
        pin = 1'b0;
        cyc(1);
        chk("R4 active-low pin low starts", st, 1);
        park();
        cfg = 4'b1011; pin = 1'b0;
        uvlo = 1'b0;
        cyc(4);
        chk("R4 active-high pin low holds off", st, 0);
        pin = 1'b1;
        cyc(1);
        chk("R4 active-high pin high starts", st, 1);
    endtask

    task automatic t_abort_on_delay();
        park();
        cfg = 4'b1100; ton = 16'd5; bon = 1'b1;
        uvlo = 1'b0;
        cyc(3);
        chk("R7 in on-delay", st, 1);
        bon = 1'b0;
        cyc(1);
        chk("R7 abort to off", st, 0);
        chk("R7 switching never enabled", sw_en, 0);
    endtask

    task automatic t_resume_off_delay();
        park();
        cfg = 4'b1100; ton = 16'd0; rise = 16'd0; toff = 16'd10; bon = 1'b1;
        uvlo = 1'b0;
        cyc(4);
        chk("R9 reached on", st, 3);
        bon = 1'b0;
        cyc(3);
        chk("R9 in off-delay", st, 4);
        bon = 1'b1;
        cyc(1);
        chk("R9 straight back to on", st, 3);
        chk("R9 no new rise", ramp, 0);
    endtask

    task automatic t_drop_in_ramp();
        park();
        cfg = 4'b1100; ton = 16'd0; rise = 16'd2; toff = 16'd3; bon = 1'b1;
        uvlo = 1'b0;
        cyc(2);
        chk("R12 in rise", st, 2);
        bon = 1'b0;
        cyc(8);
        chk("R12 rise not cut short", st, 2);
        cyc(1);
        chk("R12 one cycle in on", st, 3);
        cyc(1);
        chk("R12 then off-delay", st, 4);
    endtask

    initial begin
        t_reset();
        t_always_on();
        t_cmd_gate();
        t_pin_gate();
        t_abort_on_delay();
        t_resume_off_delay();
        t_drop_in_ramp();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule